// File: doc/BRIEF.md
# Converter Calibration and Averaging Front-End

This block sits between a register bus and a 12-bit successive-approximation converter. Software uses it to run a self-calibration pass before normal operation. The pass sets a completion flag that can raise an interrupt, and it leaves a failure flag behind when it is cut short. After calibration, conversions start in one of two ways. In software mode, writing a channel code into the first slot starts a conversion. In triggered mode, each pulse on an external trigger input walks through a small table of channel slots.

Each result can be a single conversion, or the mean of 4, 8, 16 or 32 conversions. The mean is taken by accumulating the samples and shifting the sum right. The result can then be cut down to 10 or 8 bits. The converter itself is reached through a start/ready port and is modelled in the testbench.

Top module: `adc_fe_top`

## Requirements
- R1: After reset, the status, result and general-status registers read 0. Every slot reads channel code 0x1F with its interrupt enable clear. irqOut and convStart are low.
- R2: Writing a 1 to bit 7 of the general-control register (address 8) while idle starts calibration. Bit 7 reads back 1 while calibration runs. After CAL_CYCLES cycles, bit 0 of the status register (address 5) is set.
- R3: A write to the configuration register (address 7) during calibration aborts it, sets bit 1 of the general-status register (address 9) and leaves the status flag clear. Starting a new calibration clears bit 1.
- R4: irqOut is high only while the completion flag is set and bit 7 (interrupt enable) of the slot that completed was set. Calibration uses the enable bit of slot 0.
- R5: A read of the result register (address 6) clears the completion flag, and irqOut falls with it.
- R6: With bit 13 of the configuration register clear, writing slot 0 (address 0) with a channel code in bits 4:0 other than 0x1F starts exactly one conversion on that channel. The result appears in bits 11:0 of address 6.
- R7: Channel code 0x1F means stopped: a slot 0 write with it starts nothing, and convStart is never raised for that code.
- R8: With bit 5 of general control set, bits 15:14 of configuration (code c) select 4<<c samples. The result is their sum shifted right by c+2.
- R9: With configuration bit 13 set, each trigIn pulse uses the slot at a pointer that starts at 0 and wraps after slot 4, then advances the pointer. A slot holding 0x1F is skipped without a conversion. Slot 0 writes start nothing in this mode.
- R10: Configuration bits 3:2 select the result width: 0 gives 8 bits (12-bit value shifted right by 4), 1 gives 10 bits (shifted right by 2), and 2 or 3 give 12 bits.
- R11: While the block is busy converting or calibrating, slot 0 writes and trigger pulses start nothing and do not move the slot pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects at the clock edge) |
| addr | input | 4 | Register word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr, combinational |
| trigIn | input | 1 | External conversion trigger, one cycle per pulse |
| convStart | output | 1 | One-cycle request to the converter |
| convChannel | output | 5 | Channel for the current conversion |
| convReady | input | 1 | Converter sample valid, one cycle |
| convData | input | 12 | Converter sample |
| irqOut | output | 1 | Completion interrupt |

## Verification
The bench goes after averaging at every sample count, including 32 full-scale samples. A design that sizes the accumulator or the shift wrong returns a wrapped or doubled mean.

It aborts a calibration part way through. A design that ignores the abort still reports completion and never shows the failure flag.

It walks the trigger table through stopped slots, past the wrap point, and with pulses that arrive while busy. A design whose pointer skips or moves too early converts the wrong channels in the wrong order.

Writes to slot 0 with the stop code, or while busy, must not start anything. A design that got this wrong would issue extra converter requests.

// File: rtl/adc_fe_pkg.sv
`timescale 1ns/1ps
package adc_fe_pkg;
  localparam int NUM_SLOTS = 5;
  localparam int CH_W      = 5;
  localparam int DATA_W    = 12;
  localparam int ACC_W     = 17;
  localparam int ADDR_W    = 4;
  localparam int BUS_W     = 16;
  localparam logic [CH_W-1:0]   CH_OFF      = 5'h1F;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_RESULT = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_GCTRL  = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_GSTAT  = 4'd9;

  typedef struct packed {
    logic accClear;
    logic accAdd;
    logic resLoad;
  } dp_strobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_CAL, ST_START, ST_WAIT, ST_FIN} fe_state_t;
endpackage

// File: rtl/adc_fe_datapath.sv
`timescale 1ns/1ps
module adc_fe_datapath
  import adc_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic              avgEn,
  input  logic [1:0]        avgSel,
  input  logic [1:0]        resMode,
  input  logic [DATA_W-1:0] convData,
  output logic              lastSample,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = 6;

  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  sampleCnt;
  logic [CNT_W-1:0]  sampleTotal;
  logic [2:0]        shiftAmt;
  logic [DATA_W-1:0] avgVal;
  logic [DATA_W-1:0] shaped;

  always_comb begin
    sampleTotal = avgEn ? (CNT_W'(4) << avgSel) : CNT_W'(1);
    lastSample  = (sampleCnt == sampleTotal - CNT_W'(1));
    shiftAmt    = avgEn ? ({1'b0, avgSel} + 3'd2) : 3'd0;
    avgVal      = DATA_W'(acc >> shiftAmt);
  end

  // result width shaping, one variant per mode code
  for (genvar m = 0; m < 1; m++) begin : g_shape
    always_comb begin
      case (resMode)
        2'd0:    shaped = avgVal >> 4;
        2'd1:    shaped = avgVal >> 2;
        default: shaped = avgVal;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      sampleCnt <= '0;
      result    <= '0;
    end else begin
      if (strobe.accClear) begin
        acc       <= '0;
        sampleCnt <= '0;
      end else if (strobe.accAdd) begin
        acc       <= acc + ACC_W'(convData);
        sampleCnt <= sampleCnt + CNT_W'(1);
      end
      if (strobe.resLoad) result <= shaped;
    end
  end
endmodule

// File: rtl/adc_fe_ctrl.sv
`timescale 1ns/1ps
module adc_fe_ctrl
  import adc_fe_pkg::*;
#(
  parameter int CAL_CYCLES = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  input  logic              trigIn,
  input  logic              convReady,
  output logic              convStart,
  output logic [CH_W-1:0]   convChannel,
  output logic              irqOut,
  output dp_strobe_t        strobe,
  input  logic              lastSample,
  input  logic [DATA_W-1:0] result,
  output logic              avgEn,
  output logic [1:0]        avgSel,
  output logic [1:0]        resMode,
  output logic              doneFlag,
  output logic              calFail,
  output logic              calBusy
);
  localparam int CAL_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam int PTR_W = $clog2(NUM_SLOTS);

  fe_state_t            state;
  logic [CH_W-1:0]      slotCh [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotIen;
  logic [BUS_W-1:0]     cfgReg;
  logic [CAL_W-1:0]     calCnt;
  logic [PTR_W-1:0]     ptr;
  logic [CH_W-1:0]      curCh;
  logic                 curIen, irqArm;
  logic hwMode, calReq, swStart, trigTake, hwHit, cfgWr, calEnd, setDone, rdResult;

  always_comb begin
    hwMode   = cfgReg[13];
    cfgWr    = wrEn && addr == ADDR_CFG;
    rdResult = rdEn && addr == ADDR_RESULT;
    calReq   = state == ST_IDLE && wrEn && addr == ADDR_GCTRL && wrData[7];
    swStart  = state == ST_IDLE && wrEn && addr == ADDR_W'(0) && !hwMode
               && wrData[CH_W-1:0] != CH_OFF;
    trigTake = state == ST_IDLE && trigIn && hwMode && !calReq;
    hwHit    = trigTake && slotCh[ptr] != CH_OFF;
    calEnd   = state == ST_CAL && !cfgWr && calCnt == CAL_W'(CAL_CYCLES - 1);
    setDone  = calEnd || state == ST_FIN;
    strobe.accClear = swStart || hwHit;
    strobe.accAdd   = state == ST_WAIT && convReady;
    strobe.resLoad  = state == ST_FIN;
    calBusy     = state == ST_CAL;
    convStart   = state == ST_START;
    convChannel = curCh;
    irqOut      = doneFlag && irqArm;
    avgSel      = cfgReg[15:14];
    resMode     = cfgReg[3:2];
  end

  always_comb begin
    rdData = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (addr == ADDR_W'(s)) rdData = {8'h00, slotIen[s], 2'b00, slotCh[s]};
    case (addr)
      ADDR_STATUS: rdData = {15'b0, doneFlag};
      ADDR_RESULT: rdData = {4'b0, result};
      ADDR_CFG:    rdData = cfgReg;
      ADDR_GCTRL:  rdData = {8'h00, calBusy, 1'b0, avgEn, 5'b0};
      ADDR_GSTAT:  rdData = {14'b0, calFail, calBusy};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) slotCh[s] <= CH_OFF;
      slotIen <= '0;
      cfgReg  <= '0;
      avgEn   <= 1'b0;
    end else if (wrEn) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (addr == ADDR_W'(s)) begin
          slotCh[s]  <= wrData[CH_W-1:0];
          slotIen[s] <= wrData[7];
        end
      if (addr == ADDR_CFG)   cfgReg <= wrData;
      if (addr == ADDR_GCTRL) avgEn  <= wrData[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      calCnt   <= '0;
      calFail  <= 1'b0;
      ptr      <= '0;
      curCh    <= CH_OFF;
      curIen   <= 1'b0;
      irqArm   <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (setDone)       doneFlag <= 1'b1;
      else if (rdResult) doneFlag <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (calReq) begin
            state   <= ST_CAL;
            calCnt  <= '0;
            calFail <= 1'b0;
          end else if (swStart) begin
            state  <= ST_START;
            curCh  <= wrData[CH_W-1:0];
            curIen <= wrData[7];
          end else if (trigTake) begin
            ptr <= (ptr == PTR_W'(NUM_SLOTS - 1)) ? '0 : ptr + PTR_W'(1);
            if (hwHit) begin
              state  <= ST_START;
              curCh  <= slotCh[ptr];
              curIen <= slotIen[ptr];
            end
          end
        end
        ST_CAL: begin
          if (cfgWr) begin
            calFail <= 1'b1;
            state   <= ST_IDLE;
          end else if (calEnd) begin
            irqArm <= slotIen[0];
            state  <= ST_IDLE;
          end else calCnt <= calCnt + CAL_W'(1);
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT:  if (convReady) state <= lastSample ? ST_FIN : ST_START;
        ST_FIN: begin
          irqArm <= curIen;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_fe_top.sv
`timescale 1ns/1ps
module adc_fe_top
  import adc_fe_pkg::*;
#(
  parameter int CAL_CYCLES = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  input  logic              trigIn,
  output logic              convStart,
  output logic [CH_W-1:0]   convChannel,
  input  logic              convReady,
  input  logic [DATA_W-1:0] convData,
  output logic              irqOut
);
  dp_strobe_t        strobe;
  logic              lastSample, avgEn, doneFlag, calFail, calBusy;
  logic [1:0]        avgSel, resMode;
  logic [DATA_W-1:0] result;

  adc_fe_ctrl #(.CAL_CYCLES(CAL_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .trigIn(trigIn), .convReady(convReady),
    .convStart(convStart), .convChannel(convChannel), .irqOut(irqOut),
    .strobe(strobe), .lastSample(lastSample), .result(result),
    .avgEn(avgEn), .avgSel(avgSel), .resMode(resMode),
    .doneFlag(doneFlag), .calFail(calFail), .calBusy(calBusy)
  );

  adc_fe_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .avgEn(avgEn), .avgSel(avgSel),
    .resMode(resMode), .convData(convData), .lastSample(lastSample),
    .result(result)
  );
endmodule

// File: rtl/adc_fe_checker.sv
`timescale 1ns/1ps
module adc_fe_checker
  import adc_fe_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              convStart,
  input logic [CH_W-1:0]   convChannel,
  input logic              doneFlag,
  input logic              calFail,
  input logic              calBusy
);
  // R7: the stop code never reaches the converter
  assert_no_stop_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> convChannel != CH_OFF);

  // R6: each request is a single-cycle pulse
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R5: the completion flag drops only after a result read
  assert_done_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(rdEn && addr == ADDR_RESULT));

  // R3: the failure flag rises only after a configuration write
  assert_fail_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calFail) |-> $past(wrEn && addr == ADDR_CFG));

  // R11: no converter request while calibrating
  assert_cal_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |-> !convStart);
endmodule

bind adc_fe_top adc_fe_checker i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .convStart(convStart), .convChannel(convChannel), .doneFlag(doneFlag),
  .calFail(calFail), .calBusy(calBusy)
);

// File: tb/test_adc_fe_top.sv
`timescale 1ns/1ps
module test_adc_fe_top;
  localparam int CAL = 64;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, trigIn = 1'b0, convReady = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        convStart, irqOut;
  logic [4:0]  convChannel;
  logic [11:0] convData = '0;

  int errors = 0, checks = 0, startCount = 0;
  logic [11:0] sampleQ[$];
  int          chLog[$];
  logic [11:0] expRes[$];
  logic        expIrq[$];

  adc_fe_top #(.CAL_CYCLES(CAL)) i_adc_fe_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .trigIn(trigIn), .convStart(convStart),
    .convChannel(convChannel), .convReady(convReady), .convData(convData),
    .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulseTrig();
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitDone(input string req);
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      rdReg(4'd5, v);
      if (v[0]) return;
    end
    chk(req, 32'd0, 32'd1);
  endtask

  function automatic logic [11:0] model(input int sum, input int lg, input int mode);
    int a = sum >> lg;
    if (mode == 0) a = a >> 4;
    else if (mode == 1) a = a >> 2;
    return 12'(a);
  endfunction

  // driver side: queue samples and the expected result
  task automatic expectConv(input int n, input int lg, input int mode, input int seed, input logic ien);
    int sum = 0;
    for (int k = 0; k < n; k++) begin
      logic [11:0] s = (seed < 0) ? 12'hFFF : 12'((k * 137 + seed * 911 + 5) & 32'hFFF);
      sampleQ.push_back(s);
      sum += int'(s);
    end
    expRes.push_back(model(sum, lg, mode));
    expIrq.push_back(ien);
  endtask

  // monitor side: wait for completion, pop and compare
  task automatic collect(input string req, input int expCh);
    logic [15:0] v;
    waitDone(req);
    #1 chk({req, " irq"}, irqOut, expIrq.pop_front());
    rdReg(4'd6, v);
    chk({req, " result"}, v, expRes.pop_front());
    #1 chk("R5 irq after read", irqOut, 0);
    if (chLog.size() > 0) chk({req, " channel"}, chLog.pop_front(), expCh);
    else chk({req, " channel"}, 32'hDEAD, expCh);
  endtask

  // behavioural converter
  initial begin
    forever begin
      @(posedge clk);
      if (convStart) begin
        startCount++;
        chLog.push_back(int'(convChannel));
        repeat (LAT) @(negedge clk);
        convData  = (sampleQ.size() > 0) ? sampleQ.pop_front() : 12'h000;
        convReady = 1'b1;
        @(negedge clk); convReady = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int sc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(4'd5, v); chk("R1 status", v, 0);
    rdReg(4'd6, v); chk("R1 result", v, 0);
    rdReg(4'd9, v); chk("R1 gstat", v, 0);
    rdReg(4'd0, v); chk("R1 slot0", v, 16'h001F);
    chk("R1 irq", irqOut, 0);
    chk("R1 start", convStart, 0);

    // R2 calibration, R4 via slot 0 enable, R7 stop code start nothing
    wrReg(4'd0, 16'h009F);
    chk("R7 stop code", startCount, 0);
    wrReg(4'd8, 16'h0080);
    rdReg(4'd8, v); chk("R2 busy bit", v[7], 1);
    idle(CAL / 2);
    rdReg(4'd5, v); chk("R2 not yet done", v[0], 0);
    waitDone("R2 done");
    rdReg(4'd8, v); chk("R2 busy cleared", v[7], 0);
    #1 chk("R4 cal irq", irqOut, 1);
    rdReg(4'd6, v);
    rdReg(4'd5, v); chk("R5 done cleared", v[0], 0);
    chk("R5 irq low", irqOut, 0);

    // R3 abort
    wrReg(4'd8, 16'h0080);
    idle(5);
    wrReg(4'd7, 16'h0008);
    rdReg(4'd9, v); chk("R3 fail set", v[1], 1);
    idle(CAL + 5);
    rdReg(4'd5, v); chk("R3 no done", v[0], 0);
    wrReg(4'd8, 16'h0080);
    rdReg(4'd9, v); chk("R3 fail cleared", v[1], 0);
    waitDone("R3 recal");
    rdReg(4'd6, v);

    // R6 single conversion, 12-bit, interrupt enabled
    expectConv(1, 0, 2, 3, 1'b1);
    wrReg(4'd0, 16'h0083);
    collect("R6", 3);
    // R4 interrupt disabled
    expectConv(1, 0, 2, 7, 1'b0);
    wrReg(4'd0, 16'h0009);
    collect("R4", 9);

    // R10 width modes
    sampleQ.push_back(12'hABC); expRes.push_back(12'h0AB); expIrq.push_back(1'b0);
    wrReg(4'd7, 16'h0000);
    wrReg(4'd0, 16'h0002);
    collect("R10 8-bit", 2);
    sampleQ.push_back(12'hABC); expRes.push_back(12'h2AF); expIrq.push_back(1'b0);
    wrReg(4'd7, 16'h0004);
    wrReg(4'd0, 16'h0002);
    collect("R10 10-bit", 2);

    // R8 averaging for every code
    wrReg(4'd8, 16'h0020);
    for (int c = 0; c < 4; c++) begin
      wrReg(4'd7, 16'(16'h0008 | (c << 14)));
      expectConv(4 << c, c + 2, 2, c + 1, 1'b1);
      wrReg(4'd0, 16'h0084);
      collect("R8 avg", 4);
      for (int k = 1; k < (4 << c); k++) void'(chLog.pop_front());
    end
    expectConv(32, 5, 2, -1, 1'b1);
    wrReg(4'd0, 16'h0084);
    collect("R8 full scale", 4);
    for (int k = 1; k < 32; k++) void'(chLog.pop_front());
    wrReg(4'd8, 16'h0000);
    wrReg(4'd7, 16'h0008);

    // R11 writes and triggers while busy are ignored
    expectConv(1, 0, 2, 11, 1'b0);
    sc = startCount;
    wrReg(4'd0, 16'h0003);
    wrReg(4'd0, 16'h0006);
    pulseTrig();
    collect("R11", 3);
    idle(LAT + 4);
    chk("R11 one start", startCount - sc, 1);

    // R9 triggered mode
    wrReg(4'd7, 16'h2008);
    wrReg(4'd1, 16'h001F);
    wrReg(4'd2, 16'h0005);
    wrReg(4'd3, 16'h0087);
    wrReg(4'd4, 16'h001F);
    sc = startCount;
    wrReg(4'd0, 16'h0002);
    idle(LAT + 4);
    chk("R9 slot0 write no start", startCount - sc, 0);
    expectConv(1, 0, 2, 21, 1'b0); pulseTrig(); collect("R9 slot0", 2);
    sc = startCount;
    pulseTrig(); idle(LAT + 4);
    chk("R9 skip slot1", startCount - sc, 0);
    expectConv(1, 0, 2, 22, 1'b0); pulseTrig(); collect("R9 slot2", 5);
    expectConv(1, 0, 2, 23, 1'b1);
    pulseTrig();
    pulseTrig();
    collect("R9 slot3", 7);
    sc = startCount;
    pulseTrig(); idle(LAT + 4);
    chk("R11 pointer held, skip slot4", startCount - sc, 0);
    expectConv(1, 0, 2, 24, 1'b0); pulseTrig(); collect("R9 wrap slot0", 2);

    idle(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule